// File: doc/BRIEF.md
# Double-Buffered DMA Pointer Controller

This block keeps the transfer pointers for two timer DMA channels: channel 0 serves the compare side and channel 1 serves the capture side. Each channel owns two pointer pairs in a small register file. A pair is one 8-bit transaction counter and one 8-bit address pointer. A per-channel select bit chooses which pair is active. Each completed 16-bit word transfer on a channel moves that channel's active address forward by one word and lowers its counter by one. When the counter reaches zero the block ends and raises a sticky end-of-block request for that channel.

Without swapping, a drained channel stalls until software reloads its counter and address. When a single global swap enable is set, every end-of-block event flips the channel's select bit. Transfers then carry on from the other pair while software refills the pair that has just drained. Both channels' select bits share one software register, but a channel's transfers are only ever steered by its own bit.

Software reaches the block through a simple write/read register port. Read data is registered and appears one cycle after the address is presented.

Top module: `dma_pingpong_ctrl`

## Requirements
- R1: After synchronous reset, every pointer entry, both select bits, the swap enable, both end-of-block flags and `sw_rdata` are zero.
- R2: Software address bit 3 = 0 selects a pointer entry. Bit 2 is the channel, bit 1 is the pair and bit 0 the field (0 = counter, 1 = address). `sw_rdata` returns the addressed value one clock after the address is presented.
- R3: A pulse on `xfer_done[c]` while channel c's active counter is nonzero decrements that counter by 1 and adds 2 to its address pointer, visible one cycle later. `ch_count` and `ch_addr` always show the pair chosen by `ch_sel[c]`.
- R4: A transfer that takes a counter from 1 to 0 sets `eob_irq[c]`. The flag stays set until software writes 1 to bit c at address 10; writing 0 to a bit has no effect, and a set in the same cycle as a clear wins.
- R5: With the swap enable (address 8, bit 0) set, each end-of-block event on channel c inverts `ch_sel[c]`, so the following transfers use the other pair.
- R6: With swap disabled, `ch_sel` keeps its value across end of block, and a `xfer_done[c]` pulse while the active counter is zero changes no pointer and raises no new flag.
- R7: Address 9 holds the select bits (bit c for channel c) and is readable and writable. A hardware toggle in the same cycle as a software write to that register takes priority for that channel's bit.
- R8: Channels are independent: an end-of-block on one channel leaves the other channel's select bit and pointers unchanged, and both channels may transfer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write strobe |
| sw_addr | input | 4 | Software register address |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Registered software read data |
| xfer_done | input | 2 | Per-channel pulse: one 16-bit word transfer completed |
| ch_addr | output | 16 | Active address pointer, channel c in bits [8c+7:8c] |
| ch_count | output | 16 | Active transaction counter, channel c in bits [8c+7:8c] |
| ch_sel | output | 2 | Active pair select per channel |
| eob_irq | output | 2 | Sticky end-of-block request per channel |

## Verification
Assertions check on every cycle that a written pointer entry takes the value hardware computed, that a swap-mode end of block always inverts the select bit and never does with swap off, that an end of block always leaves its flag set and a flag drops only on a clearing write, and that a drained channel stays frozen. Only the bench scenarios can show the actual register map decoding, the arithmetic values reached after several transfers, the handover to the refilled pair, and the outcome of simultaneous hardware and software writes to the select and flag registers.

// File: rtl/dma_pp_pkg.sv
package dma_pp_pkg;

  // Control register offsets inside the control window (address MSB = 1).
  typedef enum logic [1:0] {
    CTL_SWAP = 2'd0,
    CTL_SEL  = 2'd1,
    CTL_IRQ  = 2'd2
  } ctl_off_e;

  // Field selector inside a pointer pair.
  typedef enum logic {
    FLD_COUNT = 1'b0,
    FLD_ADDR  = 1'b1
  } ptr_fld_e;

endpackage

// File: rtl/dma_pp_ptr_file.sv
module dma_pp_ptr_file #(
  parameter int NUM_CH = 2,
  parameter int DW     = 8,
  localparam int IW    = $clog2(NUM_CH) + 2,
  localparam int DEPTH = NUM_CH * 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sw_we,
  input  logic [IW-1:0]        sw_idx,
  input  logic [DW-1:0]        sw_wdata,
  output logic [DW-1:0]        sw_rval,
  input  logic [NUM_CH-1:0]    hw_we,
  input  logic [NUM_CH*DW-1:0] hw_cnt,
  input  logic [NUM_CH*DW-1:0] hw_adr,
  input  logic [NUM_CH-1:0]    pair_sel,
  output logic [NUM_CH*DW-1:0] cur_cnt,
  output logic [NUM_CH*DW-1:0] cur_adr
);
  import dma_pp_pkg::*;

  logic [DW-1:0] mem [DEPTH];

  function automatic logic [IW-1:0] ent_idx(input int ch, input logic pair, input logic fld);
    return IW'((ch << 2) | (int'(pair) << 1) | int'(fld));
  endfunction

  // Software writes first; a hardware update of the same entry overrides it.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (sw_we) mem[sw_idx] <= sw_wdata;
      for (int c = 0; c < NUM_CH; c++) begin
        if (hw_we[c]) begin
          mem[ent_idx(c, pair_sel[c], FLD_COUNT)] <= hw_cnt[c*DW +: DW];
          mem[ent_idx(c, pair_sel[c], FLD_ADDR)]  <= hw_adr[c*DW +: DW];
        end
      end
    end
  end

  assign sw_rval = mem[sw_idx];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_rd
    assign cur_cnt[g*DW +: DW] = mem[ent_idx(g, pair_sel[g], FLD_COUNT)];
    assign cur_adr[g*DW +: DW] = mem[ent_idx(g, pair_sel[g], FLD_ADDR)];

    AST_HW_CNT_LANDS: assert property (@(posedge clk) disable iff (rst)
      hw_we[g] |=> mem[ent_idx(g, $past(pair_sel[g]), FLD_COUNT)] == $past(hw_cnt[g*DW +: DW])); // R3
    AST_HW_ADR_LANDS: assert property (@(posedge clk) disable iff (rst)
      hw_we[g] |=> mem[ent_idx(g, $past(pair_sel[g]), FLD_ADDR)] == $past(hw_adr[g*DW +: DW])); // R3
  end

endmodule

// File: rtl/dma_pp_chan_seq.sv
module dma_pp_chan_seq #(
  parameter int DW   = 8,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer_done,
  input  logic          swap_en,
  input  logic [DW-1:0] cur_cnt,
  input  logic [DW-1:0] cur_adr,
  input  logic          sel_we,
  input  logic          sel_wdata,
  output logic          hw_we,
  output logic [DW-1:0] hw_cnt,
  output logic [DW-1:0] hw_adr,
  output logic          eob,
  output logic          sel
);

  logic live;

  always_comb begin
    live   = xfer_done && (cur_cnt != '0);
    hw_we  = live;
    hw_cnt = cur_cnt - DW'(1);
    hw_adr = cur_adr + DW'(STEP);
    eob    = live && (cur_cnt == DW'(1));
  end

  // Hardware toggle beats a same-cycle software write.
  always_ff @(posedge clk) begin
    if (rst)                sel <= 1'b0;
    else if (eob && swap_en) sel <= ~sel;
    else if (sel_we)         sel <= sel_wdata;
  end

  AST_SWAP_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (eob && swap_en) |=> (sel != $past(sel))); // R5
  AST_SEL_HOLD_NOSWAP: assert property (@(posedge clk) disable iff (rst)
    (!swap_en && !sel_we) |=> $stable(sel)); // R6

endmodule

// File: rtl/dma_pingpong_ctrl.sv
module dma_pingpong_ctrl
  import dma_pp_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int DW        = 8,
  parameter int ADDR_STEP = 2,
  localparam int IW       = $clog2(NUM_CH) + 2,
  localparam int SW_AW    = IW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sw_we,
  input  logic [SW_AW-1:0]     sw_addr,
  input  logic [DW-1:0]        sw_wdata,
  output logic [DW-1:0]        sw_rdata,
  input  logic [NUM_CH-1:0]    xfer_done,
  output logic [NUM_CH*DW-1:0] ch_addr,
  output logic [NUM_CH*DW-1:0] ch_count,
  output logic [NUM_CH-1:0]    ch_sel,
  output logic [NUM_CH-1:0]    eob_irq
);

  logic                 is_ptr, wr_ptr, wr_swap, wr_sel, wr_irq;
  logic                 swap_en_q;
  logic [NUM_CH-1:0]    irq_q, hw_we, eob;
  logic [NUM_CH*DW-1:0] hw_cnt, hw_adr, cur_cnt, cur_adr;
  logic [DW-1:0]        file_rval, rd_mux, rdata_q;

  always_comb begin
    is_ptr  = !sw_addr[SW_AW-1];
    wr_ptr  = sw_we && is_ptr;
    wr_swap = sw_we && !is_ptr && (sw_addr[IW-1:0] == IW'(CTL_SWAP));
    wr_sel  = sw_we && !is_ptr && (sw_addr[IW-1:0] == IW'(CTL_SEL));
    wr_irq  = sw_we && !is_ptr && (sw_addr[IW-1:0] == IW'(CTL_IRQ));
  end

  dma_pp_ptr_file #(.NUM_CH(NUM_CH), .DW(DW)) i_file (
    .clk      (clk),
    .rst      (rst),
    .sw_we    (wr_ptr),
    .sw_idx   (sw_addr[IW-1:0]),
    .sw_wdata (sw_wdata),
    .sw_rval  (file_rval),
    .hw_we    (hw_we),
    .hw_cnt   (hw_cnt),
    .hw_adr   (hw_adr),
    .pair_sel (ch_sel),
    .cur_cnt  (cur_cnt),
    .cur_adr  (cur_adr)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dma_pp_chan_seq #(.DW(DW), .STEP(ADDR_STEP)) i_seq (
      .clk       (clk),
      .rst       (rst),
      .xfer_done (xfer_done[g]),
      .swap_en   (swap_en_q),
      .cur_cnt   (cur_cnt[g*DW +: DW]),
      .cur_adr   (cur_adr[g*DW +: DW]),
      .sel_we    (wr_sel),
      .sel_wdata (sw_wdata[g]),
      .hw_we     (hw_we[g]),
      .hw_cnt    (hw_cnt[g*DW +: DW]),
      .hw_adr    (hw_adr[g*DW +: DW]),
      .eob       (eob[g]),
      .sel       (ch_sel[g])
    );

    // Sticky flag: hardware set wins over a software clear.
    always_ff @(posedge clk) begin
      if (rst)                       irq_q[g] <= 1'b0;
      else if (eob[g])               irq_q[g] <= 1'b1;
      else if (wr_irq && sw_wdata[g]) irq_q[g] <= 1'b0;
    end

    AST_EOB_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
      eob[g] |=> eob_irq[g]); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (eob_irq[g] && !(wr_irq && sw_wdata[g])) |=> eob_irq[g]); // R4
    AST_DRAINED_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (xfer_done[g] && cur_cnt[g*DW +: DW] == '0 && !sw_we)
        |=> ($stable(ch_count[g*DW +: DW]) && $stable(ch_addr[g*DW +: DW]))); // R6
  end

  always_ff @(posedge clk) begin
    if (rst)          swap_en_q <= 1'b0;
    else if (wr_swap) swap_en_q <= sw_wdata[0];
  end

  always_comb begin
    rd_mux = '0;
    if (is_ptr) begin
      rd_mux = file_rval;
    end else begin
      case (sw_addr[IW-1:0])
        IW'(CTL_SWAP): rd_mux = DW'(swap_en_q);
        IW'(CTL_SEL):  rd_mux = DW'(ch_sel);
        IW'(CTL_IRQ):  rd_mux = DW'(irq_q);
        default:       rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign sw_rdata = rdata_q;
  assign ch_count = cur_cnt;
  assign ch_addr  = cur_adr;
  assign eob_irq  = irq_q;

endmodule

// File: tb/test_dma_pingpong_ctrl.sv
module test_dma_pingpong_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_we = 1'b0;
  logic [3:0]  sw_addr = '0;
  logic [7:0]  sw_wdata = '0;
  logic [7:0]  sw_rdata;
  logic [1:0]  xfer_done = '0;
  logic [15:0] ch_addr, ch_count;
  logic [1:0]  ch_sel, eob_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } rd_item_t;

  rd_item_t rd_q[$];
  logic rd_req = 1'b0, rd_req_d = 1'b0;

  always #5 clk = ~clk;

  dma_pingpong_ctrl i_dma_pingpong_ctrl (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .xfer_done(xfer_done), .ch_addr(ch_addr),
    .ch_count(ch_count), .ch_sel(ch_sel), .eob_irq(eob_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares registered read data against the scoreboard queue.
  always @(posedge clk) rd_req_d <= rd_req;
  always @(negedge clk) begin
    if (rd_req_d && rd_q.size() > 0) begin
      rd_item_t it;
      it = rd_q.pop_front();
      chk(it.tag, {24'd0, sw_rdata}, {24'd0, it.exp});
    end
  end

  // Driver tasks: each starts and ends on a falling edge.
  task automatic sw_write(input logic [3:0] a, input logic [7:0] d);
    sw_we = 1'b1; sw_addr = a; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic sw_read(input logic [3:0] a, input logic [7:0] e, input string tag);
    rd_item_t it;
    it.exp = e; it.tag = tag;
    rd_q.push_back(it);
    sw_addr = a; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic pulse(input logic [1:0] m);
    xfer_done = m;
    @(negedge clk);
    xfer_done = 2'b00;
  endtask

  task automatic pulse_wr(input logic [1:0] m, input logic [3:0] a, input logic [7:0] d);
    xfer_done = m; sw_we = 1'b1; sw_addr = a; sw_wdata = d;
    @(negedge clk);
    xfer_done = 2'b00; sw_we = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 ch_sel", ch_sel, 0);
    chk("R1 eob_irq", eob_irq, 0);
    chk("R1 ch_count", ch_count, 0);
    chk("R1 sw_rdata", sw_rdata, 0);
    sw_read(4'd8, 8'h00, "R1 swap enable");
    sw_read(4'd10, 8'h00, "R1 irq reg");
    sw_read(4'd7, 8'h00, "R1 pointer entry");

    // R2 pointer map: {ch, pair, field}
    sw_write(4'd0, 8'd3);  sw_write(4'd1, 8'h10);
    sw_write(4'd2, 8'd2);  sw_write(4'd3, 8'h40);
    sw_write(4'd4, 8'd1);  sw_write(4'd5, 8'h80);
    sw_write(4'd6, 8'd2);  sw_write(4'd7, 8'hC0);
    sw_read(4'd3, 8'h40, "R2 ch0 pair1 addr");
    sw_read(4'd6, 8'd2, "R2 ch1 pair1 count");
    chk("R3 active count mux", ch_count, 16'h0103);
    chk("R3 active addr mux", ch_addr, 16'h8010);

    // R4/R6 end of block without swap on channel 1
    pulse(2'b10);
    chk("R3 ch1 count dec", ch_count, 16'h0003);
    chk("R3 ch1 addr step", ch_addr, 16'h8210);
    chk("R4 ch1 flag set", eob_irq, 2'b10);
    chk("R6 sel held", ch_sel, 2'b00);
    pulse(2'b10);
    chk("R6 drained count", ch_count, 16'h0003);
    chk("R6 drained addr", ch_addr, 16'h8210);
    sw_write(4'd10, 8'h01);
    chk("R4 write other bit", eob_irq, 2'b10);
    sw_write(4'd10, 8'h02);
    chk("R4 clear", eob_irq, 2'b00);
    chk("R6 no new flag", eob_irq, 2'b00);

    // R5 swap on channel 0
    sw_write(4'd8, 8'h01);
    pulse(2'b01);
    chk("R3 ch0 first word", ch_count[7:0], 8'd2);
    pulse(2'b01);
    chk("R3 ch0 second word addr", ch_addr[7:0], 8'h14);
    pulse(2'b01);
    chk("R5 ch0 sel flipped", ch_sel, 2'b01);
    chk("R5 ch0 pair1 count", ch_count, 16'h0002);
    chk("R5 ch0 pair1 addr", ch_addr, 16'h8240);
    chk("R4 ch0 flag", eob_irq, 2'b01);
    sw_read(4'd0, 8'd0, "R2 ch0 pair0 drained count");
    sw_read(4'd1, 8'h16, "R3 ch0 pair0 final addr");

    // refill drained pairs, then R8 simultaneous transfers
    sw_write(4'd0, 8'd1); sw_write(4'd1, 8'h20);
    sw_write(4'd4, 8'd1); sw_write(4'd5, 8'h90);
    chk("R8 before both", ch_count, 16'h0102);
    pulse(2'b11);
    chk("R8 both count", ch_count, 16'h0201);
    chk("R8 both addr", ch_addr, 16'hC042);
    chk("R8 both sel", ch_sel, 2'b11);
    chk("R8 both flags", eob_irq, 2'b11);

    // R7 hardware toggle beats software write of select
    pulse_wr(2'b01, 4'd9, 8'h01);
    chk("R7 hw wins ch0, sw ch1", ch_sel, 2'b00);
    chk("R7 outputs follow", ch_count, 16'h0001);
    chk("R8 ch1 addr untouched", ch_addr[15:8], 8'h92);
    sw_write(4'd9, 8'h02);
    chk("R7 sw select", ch_sel, 2'b10);
    chk("R7 ch1 pair1 shown", ch_count[15:8], 8'd2);
    sw_read(4'd9, 8'h02, "R7 select readback");

    // R4 set wins over same-cycle clear
    sw_write(4'd10, 8'h03);
    chk("R4 clear both", eob_irq, 2'b00);
    pulse_wr(2'b01, 4'd10, 8'h01);
    chk("R4 set beats clear", eob_irq, 2'b01);
    chk("R5 ch0 flip again", ch_sel, 2'b11);

    // R6 swap off: select holds at end of block
    sw_write(4'd8, 8'h00);
    sw_write(4'd2, 8'd1);
    pulse(2'b01);
    chk("R6 sel holds swap off", ch_sel, 2'b11);
    chk("R6 ch0 count zero", ch_count[7:0], 8'd0);
    chk("R6 ch0 addr", ch_addr[7:0], 8'h46);
    sw_read(4'd8, 8'h00, "R6 swap disabled readback");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", rd_q.size(), 0);
    finished = 1'b1;
    finish_run();
  end

endmodule